// File: doc/BRIEF.md
# Selectable Clock Output Divider

This block drives one external clock pin from one of four clock sources: an internal RC oscillator, a low-speed 32.768 kHz oscillator, a high-speed oscillator and the system clock. Every source reaches the block as a single-cycle tick-enable in one fast reference clock domain. A divider counts the ticks of the selected source and toggles the output, so the pin carries a square wave at the source rate divided by a power of two. The set of ratios that a 3-bit divide code selects depends on the source. The low-speed source jumps to large ratios for its upper codes. The system clock may only pass through undivided.

Software programs the block through one 16-bit control word. The word holds an enable, a 2-bit source select and a 3-bit divide code. A write is a plain single-cycle strobe with no address and no handshake. The stored word can always be read back. When the output is driven from the system clock, a sleep input silences it, because that clock stops in low-power modes. Any write that moves the source or the ratio first clears the divider, so a shortened pulse never reaches the pin.

Top module: `clkout_div_top`

## Requirements
- R1: After reset, rd_data reads 0x0000 and clk_out is low.
- R2: Control word layout: bit 0 is the enable, bits 3:2 the source select, bits 6:4 the divide code. Bits 1 and 15:7 are ignored on write and read as 0, so writing 0xFFFF reads back 0x007D.
- R3: With source 0 (internal RC) or source 2 (high-speed), divide code c gives the ratio 2^c, for c from 0 to 7.
- R4: With source 1 (low-speed), codes 0..3 give ratios 1, 2, 4 and 8, and codes 4..7 give 256, 1024, 4096 and 32768.
- R5: With source 3 (system clock), code 0 gives ratio 1. Codes 1..7 are reserved and hold clk_out low.
- R6: For a ratio N of 2 or more, clk_out toggles after every N/2 ticks of the selected source. Its period is N ticks and its high time is N/2 ticks.
- R7: For ratio 1, clk_out is high for exactly one reference cycle per source tick, starting one cycle after the tick.
- R8: While the enable is 0, clk_out is low and the divider is cleared. After re-enabling, the output resumes with the full programmed period.
- R9: A write that changes the source or the divide code makes clk_out low in the following cycle and restarts the count. A write that leaves both unchanged does not disturb the output.
- R10: sleep holds clk_out low only while source 3 is selected. With other sources, sleep has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write data |
| rd_data | output | 16 | Stored control word, reserved bits zero |
| tick_src | input | 4 | Per-source tick enables, bit index equals source code |
| sleep | input | 1 | Low-power indication, gates the system clock source |
| clk_out | output | 1 | Divided clock output |

## Verification
The bench sweeps every legal source and code pairing in a shuffled order, with randomised tick spacing. It measures both period and high time, so a wrong entry in the low-speed ratio table, or an off-by-one in the half-period compare, shows up as a wrong length. The reserved system-clock codes, the disabled state and sleep with the system clock source are each watched for any high cycle. A design that decodes them as legal, or fails to gate them, would pulse the pin. A write that changes the ratio on a constantly high divide-by-one output must produce exactly one low cycle. A write with identical settings must produce none, which catches both a missing restart and a restart on every write. Sleep is also applied with another source selected, to catch gating that is too broad.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int DATA_W  = 16;
  localparam int NSRC    = 4;
  localparam int SRC_W   = $clog2(NSRC);
  localparam int DIV_W   = 3;
  localparam int SHIFT_W = 4;
  localparam int MAX_SHIFT = 15;

  typedef enum logic [SRC_W-1:0] {
    SRC_RC  = 2'd0,
    SRC_LS  = 2'd1,
    SRC_HS  = 2'd2,
    SRC_SYS = 2'd3
  } src_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    src_e             src;
    logic             en;
  } ctrl_t;

  // Low-speed source: upper codes step the exponent by two, last one by three.
  function automatic logic [SHIFT_W-1:0] ls_shift(input logic [DIV_W-1:0] code);
    logic [SHIFT_W-1:0] s;
    if (!code[2]) s = SHIFT_W'(code);
    else if (code == 3'd7) s = SHIFT_W'(MAX_SHIFT);
    else s = SHIFT_W'(8) + SHIFT_W'({code[1:0], 1'b0});
    return s;
  endfunction
endpackage

// File: rtl/clkout_regs.sv
module clkout_regs
  import clkout_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output ctrl_t             ctrl,
  output logic              restart
);
  localparam int PAD_W = DATA_W - 7;

  ctrl_t nxt;

  always_comb begin
    nxt.en  = wr_data[0];
    nxt.src = src_e'(wr_data[3:2]);
    nxt.div = wr_data[6:4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (wr_en) ctrl <= nxt;
  end

  assign restart = wr_en && ((nxt.src != ctrl.src) || (nxt.div != ctrl.div));
  assign rd_data = {{PAD_W{1'b0}}, ctrl.div, ctrl.src, 1'b0, ctrl.en};

  p_write_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & 16'h007D));
endmodule

// File: rtl/clkout_ratio.sv
module clkout_ratio
  import clkout_pkg::*;
(
  input  src_e               src,
  input  logic [DIV_W-1:0]   div,
  output logic [SHIFT_W-1:0] shift,
  output logic               legal
);
  always_comb begin
    shift = '0;
    legal = 1'b1;
    unique case (src)
      SRC_RC, SRC_HS: shift = SHIFT_W'(div);
      SRC_LS:         shift = ls_shift(div);
      SRC_SYS: begin
        shift = '0;
        legal = (div == '0);
      end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/clkout_counter.sv
module clkout_counter
  import clkout_pkg::*;
#(
  parameter int CNT_W = MAX_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               legal,
  input  logic               restart,
  input  logic               gate,
  input  logic               tick,
  input  logic [SHIFT_W-1:0] shift,
  output logic               out
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic             out_q;
  logic             hold;

  always_comb begin
    if (shift == '0) half_m1 = '0;
    else half_m1 = (CNT_W'(1) << (shift - SHIFT_W'(1))) - CNT_W'(1);
  end

  assign hold = !en || !legal || restart || gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      out_q <= 1'b0;
    end else if (hold) begin
      cnt   <= '0;
      out_q <= 1'b0;
    end else if (shift == '0) begin
      cnt   <= '0;
      out_q <= tick;
    end else if (tick) begin
      if (cnt == half_m1) begin
        cnt   <= '0;
        out_q <= ~out_q;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign out = out_q;

  p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out);
  p_restart_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !out);
  p_sleep_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gate |=> !out);
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && legal && shift != '0) |-> cnt <= half_m1);
  p_pass_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && shift == '0) |=> out == $past(tick));
endmodule

// File: rtl/clkout_div_top.sv
module clkout_div_top
  import clkout_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic [3:0]  tick_src,
  input  logic        sleep,
  output logic        clk_out
);
  ctrl_t              ctrl;
  logic               restart;
  logic [SHIFT_W-1:0] shift;
  logic               legal;
  logic               tick_sel;
  logic               gate;

  clkout_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ctrl(ctrl), .restart(restart)
  );

  clkout_ratio u_ratio (
    .src(ctrl.src), .div(ctrl.div), .shift(shift), .legal(legal)
  );

  assign tick_sel = tick_src[ctrl.src];
  assign gate     = sleep && (ctrl.src == SRC_SYS);

  clkout_counter #(.CNT_W(MAX_SHIFT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .legal(legal),
    .restart(restart), .gate(gate), .tick(tick_sel), .shift(shift),
    .out(clk_out)
  );

  p_sys_reserved_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.src == SRC_SYS && ctrl.div != '0) |=> !clk_out);
endmodule

// File: tb/sim_clkout_div_top.sv
module sim_clkout_div_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [3:0]  tick_src = '0;
  logic        sleep = 1'b0;
  logic        clk_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int tp[4] = '{2, 2, 2, 2};
  int tc[4] = '{0, 0, 0, 0};

  always #2 clk = ~clk;

  clkout_div_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick_src(tick_src), .sleep(sleep), .clk_out(clk_out)
  );

  always @(negedge clk) begin
    for (int s = 0; s < 4; s++) begin
      if (tc[s] >= tp[s] - 1) begin
        tc[s] <= 0;
        tick_src[s] <= 1'b1;
      end else begin
        tc[s] <= tc[s] + 1;
        tick_src[s] <= 1'b0;
      end
    end
  end

  function automatic int ratio_of(input int src, input int code);
    int ls[8] = '{1, 2, 4, 8, 256, 1024, 4096, 32768};
    if (src == 1) return ls[code];
    if (src == 3) return (code == 0) ? 1 : 0;
    return 1 << code;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] word(input int en, input int src, input int code);
    return 16'((code << 4) | (src << 2) | en);
  endfunction

  task automatic watch_low(input int n, input string tag);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_out !== 1'b0) highs++;
    end
    chk(highs == 0, tag, highs, 0);
  endtask

  task automatic measure(input int lim, output int per, output int hi);
    int n = 0;
    while (clk_out !== 1'b0 && n < lim) begin @(negedge clk); n++; end
    while (clk_out !== 1'b1 && n < lim) begin @(negedge clk); n++; end
    hi = 0;
    while (clk_out === 1'b1 && n < lim) begin @(negedge clk); hi++; n++; end
    per = hi;
    while (clk_out === 1'b0 && n < lim) begin @(negedge clk); per++; n++; end
    if (n >= lim) begin per = -1; hi = -1; end
  endtask

  task automatic run_combo(input int src, input int code, input string tag);
    int n, per, hi, ehi;
    n = ratio_of(src, code);
    tp[src] = (n >= 256) ? 1 : 2 + int'($urandom % 3);
    write_ctrl(word(1, src, code));
    measure(4 * n * tp[src] + 40, per, hi);
    ehi = (n == 1) ? 1 : (n / 2) * tp[src];
    chk(per == n * tp[src], {tag, " period"}, per, n * tp[src]);
    chk(hi == ehi, (n == 1) ? "R7 high time" : "R6 high time", hi, ehi);
  endtask

  initial begin
    int combo[25];
    int per, hi;
    void'($urandom(32'h1F0C));
    repeat (4) @(negedge clk);
    chk(rd_data == 16'h0000, "R1 rd_data", rd_data, 0);
    chk(clk_out == 1'b0, "R1 clk_out", clk_out, 0);
    rst_n = 1'b1;

    // R2: reserved bits dropped; source 3 code 7 is reserved (R5)
    tp[3] = 1;
    write_ctrl(16'hFFFF);
    chk(rd_data == 16'h007D, "R2 readback", rd_data, 16'h007D);
    watch_low(40, "R5 reserved code 7");
    write_ctrl(16'h0000);
    chk(rd_data == 16'h0000, "R2 clear", rd_data, 0);

    // shuffled sweep of all legal pairings (R3 R4 R5 R6 R7)
    for (int i = 0; i < 25; i++) combo[i] = (i < 24) ? ((i / 8) * 8 + (i % 8)) : 24;
    for (int i = 24; i > 0; i--) begin
      int j = int'($urandom % (i + 1));
      int t = combo[i];
      combo[i] = combo[j];
      combo[j] = t;
    end
    for (int i = 0; i < 25; i++) begin
      if (combo[i] == 24) run_combo(3, 0, "R5 sys div1");
      else begin
        int s = (combo[i] / 8 == 0) ? 0 : (combo[i] / 8 == 1) ? 1 : 2;
        run_combo(s, combo[i] % 8, (s == 1) ? "R4 low-speed" : "R3 rc/hs");
      end
    end

    // R5: every reserved system-clock code stays low
    tp[3] = 1;
    for (int c = 1; c < 8; c++) begin
      write_ctrl(word(1, 3, c));
      watch_low(20, "R5 reserved code");
    end

    // R8: disable, then resume with same settings
    tp[0] = 2;
    write_ctrl(word(1, 0, 2));
    repeat (10) @(negedge clk);
    write_ctrl(word(0, 0, 2));
    watch_low(60, "R8 disabled");
    write_ctrl(word(1, 0, 2));
    measure(200, per, hi);
    chk(per == 8, "R8 resume period", per, 8);

    // R9: restart on change, none on identical write
    tp[0] = 1; tp[2] = 1;
    write_ctrl(word(1, 0, 0));
    repeat (3) @(negedge clk);
    chk(clk_out == 1'b1, "R9 setup high", clk_out, 1);
    write_ctrl(word(1, 0, 0));
    chk(clk_out == 1'b1, "R9 same write no restart", clk_out, 1);
    write_ctrl(word(1, 2, 0));
    chk(clk_out == 1'b0, "R9 change forces low", clk_out, 0);
    @(negedge clk);
    chk(clk_out == 1'b1, "R9 resumes", clk_out, 1);

    // R10: sleep gates only the system clock source
    tp[3] = 2;
    write_ctrl(word(1, 3, 0));
    sleep = 1'b1;
    watch_low(60, "R10 sleep gates sys");
    sleep = 1'b0;
    measure(100, per, hi);
    chk(per == 2 && hi == 1, "R10 sys after wake", per, 2);
    tp[0] = 2;
    sleep = 1'b1;
    write_ctrl(word(1, 0, 3));
    measure(200, per, hi);
    chk(per == 16, "R10 sleep ignored on rc", per, 16);
    sleep = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule